// File: doc/BRIEF.md
# Banked CPU Effective Address Generator

This block forms the 24-bit effective address that a 16-bit processor core with an 8-bit compatibility (emulation) mode needs for one memory operand. The sequencer presents an addressing-mode code, the instruction operand and the current index, stack, direct-page and bank register values, together with the emulation and index-width flags, and pulses a valid strobe. One clock later the block returns the effective address, a dummy address for the throwaway cycle of indexed accesses, a carry mask that bounds how far a multi-byte access may increment the address, and two hints that let the sequencer drop a penalty cycle or a dummy cycle.

Decode, bus sequencing and the register file sit outside; the block is pure address arithmetic followed by one output register, so its result can be consumed in the cycle after the operand is known.

Top module: `bank_ea_gen`

## Requirements
- R1: After reset every output is zero. Results appear on the outputs one clock after a cycle with `in_valid` high, `out_valid` is high in exactly that following cycle, and the outputs hold their values while `in_valid` is low.
- R2: Mode codes are: 0 absolute, 1 absolute+X, 2 absolute+Y, 3 direct, 4 direct+X, 5 direct+Y, 6 stack-relative, 7 absolute+X indirect (jump table), 8 stack top; codes 9 to 15 give all outputs zero. When `idx8` is 1, X and Y enter every sum with their high byte forced to zero; otherwise all 16 bits are used.
- R3: Absolute mode gives `{dbr,16'h0} + operand` over 24 bits; the dummy address equals the address and the increment mask is 24'hFFFFFF.
- R4: Absolute+X/Y give `{dbr,16'h0} + operand + index` over 24 bits (carry may enter the bank byte), dummy address `{dbr, operand[15:8], ea[7:0]}`, mask 24'hFFFFFF; `skip_dummy` is 1 only when `rd_only` is 1 and the two addresses are equal.
- R5: Direct mode gives bank 0 and `(d + operand) mod 65536`; `skip_penalty` is 1 in the three direct modes exactly when `d[7:0]` is zero, and 0 in all other modes.
- R6: Direct+X/Y in emulation mode take the high byte from `d[15:8]` and the low byte from the low byte of `d + operand + index`; in native mode the full 16-bit sum. Bank is 0; the dummy address is `{8'h00, d[15:8], ea[7:0]}`.
- R7: The increment mask is 24'h0000FF in direct mode when `emu` is 1 and `d[7:0]` is zero; 24'h00FFFF for the other direct, stack and jump-table modes.
- R8: Stack-relative mode gives bank 0 and `(s + operand) mod 65536`.
- R9: Absolute+X indirect gives `{pbr, (operand + X) mod 65536}`.
- R10: Stack-top mode gives `{8'h00, 8'h01, s[7:0]}` when `emu` is 1 and `{8'h00, s}` otherwise.
- R11: In every mode other than 1 and 2, `skip_dummy` is 0 and the dummy address equals the effective address, except the direct-indexed dummy of R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands valid, compute this cycle |
| mode | input | 4 | Addressing-mode code (R2) |
| rd_only | input | 1 | Access is read-only (allows dummy skip) |
| emu | input | 1 | Emulation (8-bit compatibility) mode |
| idx8 | input | 1 | Index registers are 8 bits wide |
| operand | input | 16 | Instruction operand |
| x_reg | input | 16 | X index register |
| y_reg | input | 16 | Y index register |
| s_reg | input | 16 | Stack pointer |
| d_reg | input | 16 | Direct-page register |
| dbr | input | 8 | Data bank |
| pbr | input | 8 | Program bank |
| out_valid | output | 1 | Result valid |
| ea | output | 24 | Effective address |
| dummy_ea | output | 24 | Dummy-cycle address |
| inc_mask | output | 24 | Carry mask for multi-byte increments |
| skip_penalty | output | 1 | Direct-page penalty cycle may be dropped |
| skip_dummy | output | 1 | Indexed dummy cycle may be dropped |

## Verification
The bench targets carries out of the 16-bit offset into the bank byte on absolute indexing, page crossings that must keep the dummy cycle, and a read-modify-write access whose addresses match but must not skip it; a design that truncated to 16 bits or ignored `rd_only` would return the wrong bank or drop a needed bus cycle. It drives direct-indexed sums that leave the page in emulation mode and offsets that wrap past 16'hFFFF, where a design missing the page wrap or the bank-0 rule would point outside the direct page. It also checks the byte-only mask, the emulation stack page and 8-bit indexing with a dirty high byte, each of which a careless design would let leak into the address.

// File: rtl/bea_pkg.sv
package bea_pkg;

    typedef enum logic [3:0] {
        AM_ABS     = 4'd0,
        AM_ABS_X   = 4'd1,
        AM_ABS_Y   = 4'd2,
        AM_DIR     = 4'd3,
        AM_DIR_X   = 4'd4,
        AM_DIR_Y   = 4'd5,
        AM_STK_REL = 4'd6,
        AM_JMP_IND = 4'd7,
        AM_STACK   = 4'd8
    } am_e;

endpackage

// File: rtl/bea_index_sel.sv
module bea_index_sel #(
    parameter int ADDR_W = 16
) (
    input  logic              narrow,
    input  logic [ADDR_W-1:0] raw,
    output logic [ADDR_W-1:0] eff
);
    localparam int HALF = ADDR_W / 2;

    always_comb begin
        eff = raw;
        if (narrow) begin
            eff[ADDR_W-1:HALF] = '0;
        end
    end
endmodule

// File: rtl/bea_addr_core.sv
module bea_addr_core
    import bea_pkg::*;
#(
    parameter int          ADDR_W     = 16,
    parameter int          BANK_W     = 8,
    parameter logic [7:0]  STACK_PAGE = 8'h01
) (
    input  am_e                       mode,
    input  logic                      rd_only,
    input  logic                      emu,
    input  logic [ADDR_W-1:0]         op,
    input  logic [ADDR_W-1:0]         xi,
    input  logic [ADDR_W-1:0]         yi,
    input  logic [ADDR_W-1:0]         s,
    input  logic [ADDR_W-1:0]         d,
    input  logic [BANK_W-1:0]         dbr,
    input  logic [BANK_W-1:0]         pbr,
    output logic [ADDR_W+BANK_W-1:0]  ea,
    output logic [ADDR_W+BANK_W-1:0]  dum,
    output logic [ADDR_W+BANK_W-1:0]  msk,
    output logic                      skip_pen,
    output logic                      skip_dum
);
    localparam int EA_W = ADDR_W + BANK_W;
    localparam int HALF = ADDR_W / 2;
    localparam logic [EA_W-1:0] M_FULL = '1;
    localparam logic [EA_W-1:0] M_WORD = {{BANK_W{1'b0}}, {ADDR_W{1'b1}}};
    localparam logic [EA_W-1:0] M_BYTE = {{(EA_W-HALF){1'b0}}, {HALF{1'b1}}};
    localparam logic [BANK_W-1:0] BANK0 = '0;

    logic [EA_W-1:0]   bank_base;
    logic [ADDR_W-1:0] ix;
    logic [ADDR_W-1:0] sum16;
    logic [ADDR_W-1:0] page;
    logic              dlow_zero;

    assign bank_base = {dbr, {ADDR_W{1'b0}}};
    assign dlow_zero = (d[HALF-1:0] == '0);

    always_comb begin
        ea       = '0;
        dum      = '0;
        msk      = '0;
        skip_pen = 1'b0;
        skip_dum = 1'b0;
        ix       = (mode == AM_ABS_Y || mode == AM_DIR_Y) ? yi : xi;
        sum16    = '0;
        page     = '0;
        case (mode)
            AM_ABS: begin
                ea  = bank_base + EA_W'(op);
                dum = ea;
                msk = M_FULL;
            end
            AM_ABS_X, AM_ABS_Y: begin
                ea       = bank_base + EA_W'(op) + EA_W'(ix);
                dum      = {dbr, op[ADDR_W-1:HALF], ea[HALF-1:0]};
                msk      = M_FULL;
                skip_dum = rd_only && (ea == dum);
            end
            AM_DIR: begin
                sum16    = d + op;
                ea       = {BANK0, sum16};
                dum      = ea;
                msk      = (emu && dlow_zero) ? M_BYTE : M_WORD;
                skip_pen = dlow_zero;
            end
            AM_DIR_X, AM_DIR_Y: begin
                sum16    = d + op + ix;
                page     = emu ? {d[ADDR_W-1:HALF], sum16[HALF-1:0]} : sum16;
                ea       = {BANK0, page};
                dum      = {BANK0, d[ADDR_W-1:HALF], page[HALF-1:0]};
                msk      = M_WORD;
                skip_pen = dlow_zero;
            end
            AM_STK_REL: begin
                sum16 = s + op;
                ea    = {BANK0, sum16};
                dum   = ea;
                msk   = M_WORD;
            end
            AM_JMP_IND: begin
                sum16 = op + xi;
                ea    = {pbr, sum16};
                dum   = ea;
                msk   = M_WORD;
            end
            AM_STACK: begin
                page = emu ? {STACK_PAGE[HALF-1:0], s[HALF-1:0]} : s;
                ea   = {BANK0, page};
                dum  = ea;
                msk  = M_WORD;
            end
            default: begin
                ea = '0;
            end
        endcase
    end
endmodule

// File: rtl/bank_ea_gen.sv
module bank_ea_gen
    import bea_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BANK_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [3:0]               mode,
    input  logic                     rd_only,
    input  logic                     emu,
    input  logic                     idx8,
    input  logic [ADDR_W-1:0]        operand,
    input  logic [ADDR_W-1:0]        x_reg,
    input  logic [ADDR_W-1:0]        y_reg,
    input  logic [ADDR_W-1:0]        s_reg,
    input  logic [ADDR_W-1:0]        d_reg,
    input  logic [BANK_W-1:0]        dbr,
    input  logic [BANK_W-1:0]        pbr,
    output logic                     out_valid,
    output logic [ADDR_W+BANK_W-1:0] ea,
    output logic [ADDR_W+BANK_W-1:0] dummy_ea,
    output logic [ADDR_W+BANK_W-1:0] inc_mask,
    output logic                     skip_penalty,
    output logic                     skip_dummy
);
    localparam int EA_W  = ADDR_W + BANK_W;
    localparam int N_IDX = 2;

    typedef struct packed {
        logic            vld;
        logic [EA_W-1:0] ea;
        logic [EA_W-1:0] dum;
        logic [EA_W-1:0] msk;
        logic            sp;
        logic            sd;
    } res_t;

    logic [ADDR_W-1:0] idx_raw [N_IDX];
    logic [ADDR_W-1:0] idx_eff [N_IDX];

    assign idx_raw[0] = x_reg;
    assign idx_raw[1] = y_reg;

    for (genvar g = 0; g < N_IDX; g++) begin : g_idx
        bea_index_sel #(.ADDR_W(ADDR_W)) u_sel (
            .narrow (idx8),
            .raw    (idx_raw[g]),
            .eff    (idx_eff[g])
        );
    end

    logic [EA_W-1:0] c_ea, c_dum, c_msk;
    logic            c_sp, c_sd;

    bea_addr_core #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_core (
        .mode     (am_e'(mode)),
        .rd_only  (rd_only),
        .emu      (emu),
        .op       (operand),
        .xi       (idx_eff[0]),
        .yi       (idx_eff[1]),
        .s        (s_reg),
        .d        (d_reg),
        .dbr      (dbr),
        .pbr      (pbr),
        .ea       (c_ea),
        .dum      (c_dum),
        .msk      (c_msk),
        .skip_pen (c_sp),
        .skip_dum (c_sd)
    );

    res_t res_d, res_q;

    always_comb begin
        res_d     = res_q;
        res_d.vld = in_valid;
        if (in_valid) begin
            res_d.ea  = c_ea;
            res_d.dum = c_dum;
            res_d.msk = c_msk;
            res_d.sp  = c_sp;
            res_d.sd  = c_sd;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign out_valid    = res_q.vld;
    assign ea           = res_q.ea;
    assign dummy_ea     = res_q.dum;
    assign inc_mask     = res_q.msk;
    assign skip_penalty = res_q.sp;
    assign skip_dummy   = res_q.sd;
endmodule

// File: rtl/bea_checker.sv
module bea_checker
    import bea_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BANK_W = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     in_valid,
    input logic [3:0]               mode,
    input logic                     emu,
    input logic [ADDR_W-1:0]        d_reg,
    input logic                     out_valid,
    input logic [ADDR_W+BANK_W-1:0] ea,
    input logic [ADDR_W+BANK_W-1:0] dummy_ea,
    input logic [ADDR_W+BANK_W-1:0] inc_mask,
    input logic                     skip_penalty,
    input logic                     skip_dummy
);
    localparam int EA_W = ADDR_W + BANK_W;

    a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(ea) && $stable(inc_mask)));
    a_r4_skip_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
        skip_dummy |-> (ea == dummy_ea));
    a_r5_penalty_bank0: assert property (@(posedge clk) disable iff (!rst_n)
        skip_penalty |-> (ea[EA_W-1:ADDR_W] == '0));
    a_r5_direct_bank0: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == AM_DIR) |=> (ea[EA_W-1:ADDR_W] == '0));
    a_r7_byte_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == AM_DIR && emu && d_reg[7:0] == 8'h00)
            |=> (inc_mask == EA_W'(8'hFF)));
    a_r10_emu_stack_page: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == AM_STACK && emu) |=> (ea[15:8] == 8'h01));
endmodule

bind bank_ea_gen bea_checker #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .mode         (mode),
    .emu          (emu),
    .d_reg        (d_reg),
    .out_valid    (out_valid),
    .ea           (ea),
    .dummy_ea     (dummy_ea),
    .inc_mask     (inc_mask),
    .skip_penalty (skip_penalty),
    .skip_dummy   (skip_dummy)
);

// File: tb/tb_bank_ea_gen.sv
`timescale 1ns/1ps
module tb_bank_ea_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  mode = '0;
    logic        rd_only = 1'b0, emu = 1'b0, idx8 = 1'b0;
    logic [15:0] operand = '0, x_reg = '0, y_reg = '0, s_reg = '0, d_reg = '0;
    logic [7:0]  dbr = '0, pbr = '0;
    logic        out_valid, skip_penalty, skip_dummy;
    logic [23:0] ea, dummy_ea, inc_mask;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    bank_ea_gen dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
        .rd_only(rd_only), .emu(emu), .idx8(idx8), .operand(operand),
        .x_reg(x_reg), .y_reg(y_reg), .s_reg(s_reg), .d_reg(d_reg),
        .dbr(dbr), .pbr(pbr), .out_valid(out_valid), .ea(ea),
        .dummy_ea(dummy_ea), .inc_mask(inc_mask),
        .skip_penalty(skip_penalty), .skip_dummy(skip_dummy)
    );

    // stimulus: mode4 rd emu idx8 op x y s d dbr pbr = 103 bits
    localparam int NV = 12;
    localparam logic [102:0] TBL [NV] = '{
        {4'd0, 1'b0, 1'b0, 1'b0, 16'hFFFF, 16'h0000, 16'h0000, 16'h01FF, 16'h0000, 8'h7E, 8'h00},
        {4'd1, 1'b1, 1'b0, 1'b0, 16'h12F0, 16'h0123, 16'h0000, 16'h0000, 16'h0000, 8'h01, 8'h00},
        {4'd2, 1'b1, 1'b1, 1'b1, 16'hFFC0, 16'h0000, 16'hA37F, 16'h0000, 16'h0000, 8'hFF, 8'h00},
        {4'd3, 1'b0, 1'b1, 1'b0, 16'h00FE, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 8'h00, 8'h00},
        {4'd3, 1'b0, 1'b0, 1'b0, 16'h0044, 16'h0000, 16'h0000, 16'h0000, 16'hFFC5, 8'h3A, 8'h00},
        {4'd4, 1'b0, 1'b1, 1'b1, 16'h00F0, 16'h5540, 16'h0000, 16'h0000, 16'h2200, 8'h00, 8'h00},
        {4'd5, 1'b0, 1'b0, 1'b0, 16'h00F0, 16'h0000, 16'h1240, 16'h0000, 16'h2201, 8'h00, 8'h00},
        {4'd6, 1'b0, 1'b0, 1'b0, 16'h0009, 16'h0000, 16'h0000, 16'hFFFB, 16'h0000, 8'h11, 8'h00},
        {4'd7, 1'b0, 1'b0, 1'b1, 16'hFFFE, 16'h3304, 16'h0000, 16'h0000, 16'h0000, 8'h00, 8'h9C},
        {4'd8, 1'b0, 1'b1, 1'b0, 16'h0000, 16'h0000, 16'h0000, 16'h7A3C, 16'h0000, 8'h00, 8'h00},
        {4'd8, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000, 16'h0000, 16'h7A3C, 16'h0000, 8'h00, 8'h00},
        {4'd12, 1'b1, 1'b1, 1'b0, 16'h1234, 16'h0001, 16'h0002, 16'h0003, 16'h0000, 8'h05, 8'h06}
    };

    // Reference model: returns {ea, dummy, mask, skip_penalty, skip_dummy}
    function automatic logic [73:0] ref_model(
        input logic [3:0] m, input logic ro, input logic em, input logic i8,
        input logic [15:0] op, input logic [15:0] xr, input logic [15:0] yr,
        input logic [15:0] sr, input logic [15:0] dr,
        input logic [7:0] db, input logic [7:0] pb);
        int xv, yv, iv, t;
        logic [23:0] a, du, mk;
        logic sp, sd;
        xv = i8 ? int'(xr & 16'h00FF) : int'(xr);
        yv = i8 ? int'(yr & 16'h00FF) : int'(yr);
        iv = (m == 4'd2 || m == 4'd5) ? yv : xv;
        a = 0; du = 0; mk = 0; sp = 0; sd = 0;
        if (m == 4'd0) begin
            a = 24'((int'(db) * 65536 + int'(op)) % 16777216);
            du = a; mk = 24'hFFFFFF;
        end else if (m == 4'd1 || m == 4'd2) begin
            a = 24'((int'(db) * 65536 + int'(op) + iv) % 16777216);
            du = 24'(int'(db) * 65536 + int'(op & 16'hFF00) + int'(a % 256));
            mk = 24'hFFFFFF;
            sd = ro && (a == du);
        end else if (m == 4'd3) begin
            a = 24'((int'(dr) + int'(op)) % 65536);
            du = a;
            sp = (dr % 256) == 0;
            mk = (em && sp) ? 24'h0000FF : 24'h00FFFF;
        end else if (m == 4'd4 || m == 4'd5) begin
            t = (int'(dr) + int'(op) + iv) % 65536;
            if (em) t = int'(dr & 16'hFF00) + t % 256;
            a = 24'(t);
            du = 24'(int'(dr & 16'hFF00) + t % 256);
            sp = (dr % 256) == 0;
            mk = 24'h00FFFF;
        end else if (m == 4'd6) begin
            a = 24'((int'(sr) + int'(op)) % 65536);
            du = a; mk = 24'h00FFFF;
        end else if (m == 4'd7) begin
            a = 24'(int'(pb) * 65536 + (int'(op) + xv) % 65536);
            du = a; mk = 24'h00FFFF;
        end else if (m == 4'd8) begin
            a = em ? 24'(256 + int'(sr % 256)) : 24'(sr);
            du = a; mk = 24'h00FFFF;
        end
        return {a, du, mk, sp, sd};
    endfunction

    task automatic apply(input logic [102:0] v);
        @(negedge clk);
        {mode, rd_only, emu, idx8, operand, x_reg, y_reg, s_reg, d_reg, dbr, pbr} = v;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_all(input string req, input logic [73:0] e);
        chk(req, 32'(ea), 32'(e[73:50]));
        chk(req, 32'(dummy_ea), 32'(e[49:26]));
        chk(req, 32'(inc_mask), 32'(e[25:2]));
        chk(req, 32'(skip_penalty), 32'(e[1]));
        chk(req, 32'(skip_dummy), 32'(e[0]));
        chk(req, 32'(out_valid), 32'd1);
    endtask

    initial begin : watchdog
        #400000;
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [23:0] held;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 reset ea", 32'(ea), 32'd0);
        chk("R1 reset valid", 32'(out_valid), 32'd0);
        chk("R1 reset mask", 32'(inc_mask), 32'd0);
        rst_n = 1'b1;

        // Table walk against reference model (R2..R11)
        for (int i = 0; i < NV; i++) begin
            apply(TBL[i]);
            chk_all("R2 table", ref_model(TBL[i][102:99], TBL[i][98], TBL[i][97], TBL[i][96],
                TBL[i][95:80], TBL[i][79:64], TBL[i][63:48], TBL[i][47:32], TBL[i][31:16],
                TBL[i][15:8], TBL[i][7:0]));
        end

        // R10 emulation stack page
        apply({4'd8, 1'b0, 1'b1, 1'b0, 16'h0, 16'h0, 16'h0, 16'h12FE, 16'h0, 8'h00, 8'h00});
        chk("R10 emu stack", 32'(ea), 32'h0001FE);
        apply({4'd8, 1'b0, 1'b0, 1'b0, 16'h0, 16'h0, 16'h0, 16'h12FE, 16'h0, 8'h00, 8'h00});
        chk("R10 native stack", 32'(ea), 32'h0012FE);

        // R2/R4 8-bit index with dirty high byte, no page cross, read-only skip
        apply({4'd1, 1'b1, 1'b0, 1'b1, 16'h1000, 16'hAB80, 16'h0, 16'h0, 16'h0, 8'h02, 8'h00});
        chk("R2 idx8 ea", 32'(ea), 32'h021080);
        chk("R4 skip when equal", 32'(skip_dummy), 32'd1);
        // R4 same addresses but read-modify-write: no skip
        apply({4'd1, 1'b0, 1'b0, 1'b1, 16'h1000, 16'hAB80, 16'h0, 16'h0, 16'h0, 8'h02, 8'h00});
        chk("R4 no skip rmw", 32'(skip_dummy), 32'd0);
        // R4 page cross
        apply({4'd1, 1'b1, 1'b0, 1'b1, 16'h10F0, 16'h0020, 16'h0, 16'h0, 16'h0, 8'h02, 8'h00});
        chk("R4 cross ea", 32'(ea), 32'h021110);
        chk("R4 cross dummy", 32'(dummy_ea), 32'h021010);
        chk("R4 cross skip", 32'(skip_dummy), 32'd0);
        // R4 carry into bank
        apply({4'd2, 1'b1, 1'b0, 1'b0, 16'hFFFF, 16'h0, 16'h0002, 16'h0, 16'h0, 8'h02, 8'h00});
        chk("R4 bank carry", 32'(ea), 32'h030001);
        chk("R4 bank carry dummy", 32'(dummy_ea), 32'h02FF01);

        // R5/R7 direct with zero low byte
        apply({4'd3, 1'b0, 1'b1, 1'b0, 16'h0034, 16'h0, 16'h0, 16'h0, 16'h1200, 8'h55, 8'h00});
        chk("R5 direct ea", 32'(ea), 32'h001234);
        chk("R5 skip penalty", 32'(skip_penalty), 32'd1);
        chk("R7 byte mask emu", 32'(inc_mask), 32'h0000FF);
        apply({4'd3, 1'b0, 1'b0, 1'b0, 16'h0034, 16'h0, 16'h0, 16'h0, 16'h1200, 8'h55, 8'h00});
        chk("R7 word mask native", 32'(inc_mask), 32'h00FFFF);
        // R5 wrap
        apply({4'd3, 1'b0, 1'b0, 1'b0, 16'h0020, 16'h0, 16'h0, 16'h0, 16'hFFF0, 8'h55, 8'h00});
        chk("R5 wrap ea", 32'(ea), 32'h000010);
        chk("R5 no skip", 32'(skip_penalty), 32'd0);

        // R6 direct indexed page wrap in emulation vs native
        apply({4'd4, 1'b0, 1'b1, 1'b0, 16'h00F8, 16'h0010, 16'h0, 16'h0, 16'h0300, 8'h00, 8'h00});
        chk("R6 emu wrap", 32'(ea), 32'h000308);
        apply({4'd4, 1'b0, 1'b0, 1'b0, 16'h00F8, 16'h0010, 16'h0, 16'h0, 16'h0300, 8'h00, 8'h00});
        chk("R6 native", 32'(ea), 32'h000408);
        chk("R6 dummy", 32'(dummy_ea), 32'h000308);

        // R8 stack relative wrap
        apply({4'd6, 1'b0, 1'b0, 1'b0, 16'h0020, 16'h0, 16'h0, 16'hFFF0, 16'h0, 8'h44, 8'h00});
        chk("R8 stack rel", 32'(ea), 32'h000010);
        // R9 jump table
        apply({4'd7, 1'b0, 1'b0, 1'b0, 16'hFFF0, 16'h0020, 16'h0, 16'h0, 16'h0, 8'h44, 8'h05});
        chk("R9 jump ind", 32'(ea), 32'h050010);
        // R11 absolute: dummy equals ea, no skip
        apply({4'd0, 1'b1, 1'b0, 1'b0, 16'h4321, 16'h0, 16'h0, 16'h0, 16'h0, 8'h09, 8'h00});
        chk("R3 abs ea", 32'(ea), 32'h094321);
        chk("R11 dummy eq", 32'(dummy_ea), 32'h094321);
        chk("R11 no skip", 32'(skip_dummy), 32'd0);

        // R1 hold while idle
        held = ea;
        @(negedge clk);
        operand = 16'hBEEF; mode = 4'd1;
        @(negedge clk);
        @(negedge clk);
        chk("R1 hold ea", 32'(ea), 32'(held));
        chk("R1 idle valid", 32'(out_valid), 32'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule